// File: doc/BRIEF.md
# RGB to YCbCr 4:2:2 Packer

This block takes a stream of 24-bit RGB pixels with a data-enable and two sync lines. It turns every active pixel into luma and two colour-difference values using fixed-point integer coefficients. It then halves the chroma rate horizontally, so that each pixel leaves as one 16-bit word: a luma byte and a chroma byte. The chroma byte carries Cb on the first pixel of a pair and Cr on the second. Each chroma byte is the mean of the two pixels in the pair.

A per-pixel bypass input turns the conversion off. The low 16 bits of the input word then go straight to the output. Data-enable and both sync lines run through a delay of the same depth as the datapath, so they stay aligned with the output words. The block sits between a frame source that produces RGB and a transmitter that expects a 16-bit 4:2:2 bus.

Top module: `pix_ycc422_pack`

## Requirements
- R1: Y = ((66*R + 129*G + 25*B + 128) >>> 8) + 16, clamped to 0..255. R is rgb_in[23:16], G is rgb_in[15:8] and B is rgb_in[7:0]. Y goes out on ycc_out[15:8].
- R2: Per-pixel Cb = ((-38*R - 74*G + 112*B + 128) >>> 8) + 128 and Cr = ((112*R - 94*G - 18*B + 128) >>> 8) + 128. The shift is arithmetic and each result is clamped to 0..255.
- R3: Pixel phase is reset at each rising edge of DE, so the first active pixel of a line is even. ycc_out[7:0] carries chroma: Cb on even pixels and Cr on odd pixels.
- R4: For a pixel pair (even k, odd k+1), the even word's chroma is (Cb_k + Cb_k+1 + 1) >> 1 and the odd word's chroma is (Cr_k + Cr_k+1 + 1) >> 1.
- R5: An even pixel that is the last active pixel of its line has no partner. Its chroma is its own Cb.
- R6: de_out, hs_out and vs_out equal de_in, hs_in and vs_in delayed by exactly 4 clock cycles. ycc_out for an input also appears 4 cycles after that input is sampled.
- R7: When bypass is high with an input word, the output 4 cycles later equals rgb_in[15:0] of that word. This holds whatever the value of DE.
- R8: When bypass is low and the delayed DE is low, ycc_out is 0.
- R9: While rst_n is low at a clock edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass | input | 1 | Per-pixel raw pass-through select |
| rgb_in | input | 24 | Pixel, R in [23:16], G in [15:8], B in [7:0] |
| de_in | input | 1 | Active-video enable |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| ycc_out | output | 16 | {Y, chroma} word or raw bypass word |
| de_out | output | 1 | Delayed enable |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |

## Verification
The bench builds the block with its default 8-bit components and fixed 4-stage latency. At that width a 16-level grid on each of R, G and B covers 4096 colours, including every primary extreme. These pixels are spread over lines of length 1, 2, 3, 5, 7, 16, 33 and 64. Odd lengths exercise the unpaired last pixel, and short lines repeat the phase reset many times. Every fifth line runs in bypass, with gap cycles that carry non-zero raw data.

// File: rtl/ycc_pkg.sv
// Package ycc_pkg: shared widths, latency and arithmetic helpers for the
// 4:2:2 packer. Assumes 8-bit colour components.
package ycc_pkg;
    localparam int COMP_W   = 8;
    localparam int RGB_W    = 3 * COMP_W;
    localparam int OUT_W    = 2 * COMP_W;
    localparam int LATENCY  = 4;
    localparam int FRAC_W   = 8;
    localparam int ROUND_K  = 1 << (FRAC_W - 1);

    // One matrix row: weighted sum, rounding, offset, clamp to a byte.
    function automatic logic [COMP_W-1:0] mat_row(
        input int kr, input int kg, input int kb, input int off,
        input logic [COMP_W-1:0] r, input logic [COMP_W-1:0] g,
        input logic [COMP_W-1:0] b);
        int acc;
        acc = kr * int'(r) + kg * int'(g) + kb * int'(b) + ROUND_K;
        acc = (acc >>> FRAC_W) + off;
        if (acc < 0)
            return '0;
        else if (acc > 255)
            return '1;
        else
            return acc[COMP_W-1:0];
    endfunction

    // Mean of two bytes, rounding half up.
    function automatic logic [COMP_W-1:0] avg2(
        input logic [COMP_W-1:0] a, input logic [COMP_W-1:0] b);
        logic [COMP_W:0] s;
        s = {1'b0, a} + {1'b0, b} + {{COMP_W{1'b0}}, 1'b1};
        return s[COMP_W:1];
    endfunction
endpackage

// File: rtl/ycc_matrix.sv
// ycc_matrix: two-stage colour matrix. Stage 1 registers the RGB input.
// Stage 2 registers Y, Cb and Cr. Assumes COMP_W = 8 and one fixed set of
// studio-range coefficients.
module ycc_matrix
    import ycc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RGB_W-1:0]  rgb_i,
    input  logic              de_i,
    output logic [COMP_W-1:0] y_o,
    output logic [COMP_W-1:0] cb_o,
    output logic [COMP_W-1:0] cr_o,
    output logic              de_o
);
    logic [COMP_W-1:0] r1, g1, b1;
    logic              de1;

    // Stage 1: capture the split colour components.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1 <= '0; g1 <= '0; b1 <= '0; de1 <= 1'b0;
        end else begin
            r1  <= rgb_i[3*COMP_W-1:2*COMP_W];
            g1  <= rgb_i[2*COMP_W-1:COMP_W];
            b1  <= rgb_i[COMP_W-1:0];
            de1 <= de_i;
        end
    end

    // Stage 2: evaluate the three matrix rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o <= '0; cb_o <= '0; cr_o <= '0; de_o <= 1'b0;
        end else begin
            y_o  <= mat_row(66, 129, 25, 16, r1, g1, b1);
            cb_o <= mat_row(-38, -74, 112, 128, r1, g1, b1);
            cr_o <= mat_row(112, -94, -18, 128, r1, g1, b1);
            de_o <= de1;
        end
    end

    assert_luma_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (y_o >= 8'd16 && y_o <= 8'd235));
    assert_chroma_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (cb_o >= 8'd16 && cb_o <= 8'd240 && cr_o >= 8'd16 && cr_o <= 8'd240));
endmodule

// File: rtl/ycc_chroma_pair.sv
// ycc_chroma_pair: two-stage chroma decimator. Stage 3 holds a pixel while
// its partner sits in stage 2. Stage 4 emits {Y, Cb-mean} for even pixels
// and {Y, Cr-mean} for odd pixels. Assumes inputs from ycc_matrix stage 2.
module ycc_chroma_pair
    import ycc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COMP_W-1:0] y_i,
    input  logic [COMP_W-1:0] cb_i,
    input  logic [COMP_W-1:0] cr_i,
    input  logic              de_i,
    output logic [OUT_W-1:0]  word_o,
    output logic              de_o
);
    logic [COMP_W-1:0] y3, cb3, cr3, cr_hold, y4, c4;
    logic              de3, odd3, odd4;
    logic [COMP_W-1:0] cb_mate, cr_mate;

    // Partner of the held pixel: the next one, or itself at line end.
    always_comb begin
        cb_mate = de_i ? cb_i : cb3;
        cr_mate = de_i ? cr_i : cr3;
    end

    // Stage 3: hold one pixel and track its phase, even after each DE rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y3 <= '0; cb3 <= '0; cr3 <= '0; de3 <= 1'b0; odd3 <= 1'b0;
        end else begin
            y3   <= y_i;
            cb3  <= cb_i;
            cr3  <= cr_i;
            de3  <= de_i;
            odd3 <= de_i && de3 && !odd3;
        end
    end

    // Stage 4: form the output bytes and keep the pair's Cr mean.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y4 <= '0; c4 <= '0; cr_hold <= '0; de_o <= 1'b0; odd4 <= 1'b0;
        end else begin
            de_o <= de3;
            odd4 <= odd3;
            if (!de3) begin
                y4 <= '0;
                c4 <= '0;
            end else if (!odd3) begin
                y4      <= y3;
                c4      <= avg2(cb3, cb_mate);
                cr_hold <= avg2(cr3, cr_mate);
            end else begin
                y4 <= y3;
                c4 <= cr_hold;
            end
        end
    end

    assign word_o = {y4, c4};

    assert_phase_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        odd4 |-> ($past(de_o) && !$past(odd4)));
    assert_odd_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        odd4 |-> de_o);
endmodule

// File: rtl/pipe_delay.sv
// pipe_delay: fixed-depth register chain for side-band bits. Assumes
// DEPTH >= 1.
module pipe_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    logic [W-1:0] tap [DEPTH+1];

    assign tap[0] = d_i;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        // One stage of the delay chain.
        always_ff @(posedge clk) begin
            if (!rst_n) tap[s+1] <= '0;
            else        tap[s+1] <= tap[s];
        end
    end

    assign d_o = tap[DEPTH];
endmodule

// File: rtl/pix_ycc422_pack.sv
// pix_ycc422_pack: RGB to 16-bit YCbCr 4:2:2 packer with raw bypass.
// Matrix (2 stages) and chroma pairing (2 stages) give a 4-cycle datapath.
// Sync, enable, bypass and the raw low word ride an equal-depth delay.
// Assumes one pixel per clock and 8-bit components.
module pix_ycc422_pack
    import ycc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic [RGB_W-1:0] rgb_in,
    input  logic             de_in,
    input  logic             hs_in,
    input  logic             vs_in,
    output logic [OUT_W-1:0] ycc_out,
    output logic             de_out,
    output logic             hs_out,
    output logic             vs_out
);
    localparam int SIDE_W = OUT_W + 4;

    logic [COMP_W-1:0] y2, cb2, cr2;
    logic              de2, de_pair;
    logic [OUT_W-1:0]  pair_word, raw_d;
    logic              bypass_d;
    logic [SIDE_W-1:0] side_in, side_out;

    ycc_matrix u_matrix (
        .clk(clk), .rst_n(rst_n), .rgb_i(rgb_in), .de_i(de_in),
        .y_o(y2), .cb_o(cb2), .cr_o(cr2), .de_o(de2)
    );

    ycc_chroma_pair u_pair (
        .clk(clk), .rst_n(rst_n), .y_i(y2), .cb_i(cb2), .cr_i(cr2),
        .de_i(de2), .word_o(pair_word), .de_o(de_pair)
    );

    assign side_in = {bypass, vs_in, hs_in, de_in, rgb_in[OUT_W-1:0]};

    pipe_delay #(.W(SIDE_W), .DEPTH(LATENCY)) u_side (
        .clk(clk), .rst_n(rst_n), .d_i(side_in), .d_o(side_out)
    );

    // Split the delayed side-band word and select the output source.
    always_comb begin
        raw_d    = side_out[OUT_W-1:0];
        de_out   = side_out[OUT_W];
        hs_out   = side_out[OUT_W+1];
        vs_out   = side_out[OUT_W+2];
        bypass_d = side_out[OUT_W+3];
        ycc_out  = bypass_d ? raw_d : pair_word;
    end

    logic [2:0] warm_cnt;

    // Count non-reset edges so latency checks see only post-reset history.
    always_ff @(posedge clk) begin
        if (!rst_n)                  warm_cnt <= '0;
        else if (warm_cnt != 3'd4)   warm_cnt <= warm_cnt + 3'd1;
    end

    assert_enable_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt == 3'd4) |-> (de_out == $past(de_in, 4) && hs_out == $past(hs_in, 4)));
    assert_pair_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        de_pair == de_out);
    assert_raw_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm_cnt == 3'd4) && $past(bypass, 4)) |-> (ycc_out == $past(rgb_in[15:0], 4)));
    assert_blank_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_d && !de_out) |-> (ycc_out == '0));
endmodule

// File: tb/pix_ycc422_pack_bench.sv
module pix_ycc422_pack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass = 1'b0;
    logic [23:0] rgb_in = '0;
    logic        de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
    logic [15:0] ycc_out;
    logic        de_out, hs_out, vs_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // Expected ring, 8 slots; kind 0 blank, 1 raw, 2 paired, 3 unpaired.
    logic [15:0] e_word [8];
    logic        e_de [8], e_hs [8], e_vs [8];
    int          e_kind [8];

    always #10 clk = ~clk;

    pix_ycc422_pack u_pix_ycc422_pack (
        .clk(clk), .rst_n(rst_n), .bypass(bypass), .rgb_in(rgb_in),
        .de_in(de_in), .hs_in(hs_in), .vs_in(vs_in), .ycc_out(ycc_out),
        .de_out(de_out), .hs_out(hs_out), .vs_out(vs_out)
    );

    function automatic int clamp(input int v);
        return (v < 0) ? 0 : (v > 255) ? 255 : v;
    endfunction
    function automatic int f_y(input int r, input int g, input int b);
        return clamp(((66*r + 129*g + 25*b + 128) >>> 8) + 16);
    endfunction
    function automatic int f_cb(input int r, input int g, input int b);
        return clamp(((-38*r - 74*g + 112*b + 128) >>> 8) + 128);
    endfunction
    function automatic int f_cr(input int r, input int g, input int b);
        return clamp(((112*r - 94*g - 18*b + 128) >>> 8) + 128);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Compare outputs with the entry from 4 steps ago, then drive a new input.
    task automatic step(input bit bp, input bit de, input bit hs, input bit vs,
                        input logic [23:0] rgb, input logic [15:0] ew, input int kind);
        int s;
        @(negedge clk);
        s = (cyc + 4) & 7;
        chk(de_out == e_de[s], "R6 de", int'(de_out), int'(e_de[s]));
        chk(hs_out == e_hs[s], "R6 hs", int'(hs_out), int'(e_hs[s]));
        chk(vs_out == e_vs[s], "R6 vs", int'(vs_out), int'(e_vs[s]));
        case (e_kind[s])
            0: chk(ycc_out == 16'h0, "R8 blank", int'(ycc_out), 0);
            1: chk(ycc_out == e_word[s], "R7 bypass", int'(ycc_out), int'(e_word[s]));
            2: begin
                chk(ycc_out[15:8] == e_word[s][15:8], "R1 luma", int'(ycc_out[15:8]), int'(e_word[s][15:8]));
                chk(ycc_out[7:0] == e_word[s][7:0], "R2/R4 R3 chroma", int'(ycc_out[7:0]), int'(e_word[s][7:0]));
            end
            default: begin
                chk(ycc_out[15:8] == e_word[s][15:8], "R1 luma", int'(ycc_out[15:8]), int'(e_word[s][15:8]));
                chk(ycc_out[7:0] == e_word[s][7:0], "R5 unpaired", int'(ycc_out[7:0]), int'(e_word[s][7:0]));
            end
        endcase
        bypass = bp; de_in = de; hs_in = hs; vs_in = vs; rgb_in = rgb;
        s = cyc & 7;
        e_word[s] = ew; e_de[s] = de; e_hs[s] = hs; e_vs[s] = vs; e_kind[s] = kind;
        cyc++;
    endtask

    initial begin
        int lens [8] = '{1, 2, 3, 7, 16, 33, 64, 5};
        int idx, ln;
        for (int k = 0; k < 8; k++) begin
            e_word[k] = '0; e_de[k] = 1'b0; e_hs[k] = 1'b0; e_vs[k] = 1'b0; e_kind[k] = 0;
        end
        // Reset state: drive non-zero inputs while reset is held.
        rgb_in = 24'hFFFFFF; de_in = 1'b1; hs_in = 1'b1; vs_in = 1'b1; bypass = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(ycc_out == 16'h0, "R9 reset data", int'(ycc_out), 0);
        chk({de_out, hs_out, vs_out} == 3'b000, "R9 reset sync", int'({de_out, hs_out, vs_out}), 0);
        rgb_in = '0; de_in = 1'b0; hs_in = 1'b0; vs_in = 1'b0; bypass = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        idx = 0;
        ln = 0;
        while (idx < 4096) begin
            int len, r[64], g[64], b[64], yy[64], cb[64], cr[64];
            bit bp, vs;
            len = lens[ln % 8];
            if (idx + len > 4096) len = 4096 - idx;
            bp = (ln % 5 == 4);
            vs = (ln % 16 == 0);
            for (int i = 0; i < len; i++) begin
                int p = idx + i;
                r[i] = ((p >> 8) & 15) * 17;
                g[i] = ((p >> 4) & 15) * 17;
                b[i] = (p & 15) * 17;
                yy[i] = f_y(r[i], g[i], b[i]);
                cb[i] = f_cb(r[i], g[i], b[i]);
                cr[i] = f_cr(r[i], g[i], b[i]);
            end
            // Blanking gap with a horizontal sync pulse; raw data non-zero.
            for (int j = 0; j < 3; j++) begin
                logic [23:0] gw = 24'((ln * 977 + j * 31 + 5) * 40503);
                step(bp, 1'b0, j == 0, vs, gw, bp ? gw[15:0] : 16'h0, bp ? 1 : 0);
            end
            for (int i = 0; i < len; i++) begin
                logic [23:0] pw = {r[i][7:0], g[i][7:0], b[i][7:0]};
                int c, kind;
                if (bp) begin
                    step(1'b1, 1'b1, 1'b0, vs, pw, pw[15:0], 1);
                end else begin
                    if ((i % 2) == 0) begin
                        if (i + 1 < len) begin
                            c = (cb[i] + cb[i+1] + 1) >> 1;
                            kind = 2;
                        end else begin
                            c = cb[i];
                            kind = 3;
                        end
                    end else begin
                        c = (cr[i-1] + cr[i] + 1) >> 1;
                        kind = 2;
                    end
                    step(1'b0, 1'b1, 1'b0, vs, pw, {yy[i][7:0], c[7:0]}, kind);
                end
            end
            idx += len;
            ln++;
        end
        for (int j = 0; j < 8; j++) step(1'b0, 1'b0, 1'b0, 1'b0, 24'h0, 16'h0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule